// File: doc/BRIEF.md
# Optical Oversampled Serial Byte Receiver

This block recovers asynchronous serial bytes that arrive as pulses of light. A light sensor feeds an ADC, and the block runs the ADC from a sample tick. Every tick starts a new conversion, and the block judges the result of the conversion that the previous tick started. Each bit period holds eight sample ticks. Only the three central samples of a bit take part in the decision. A sample is dark when the ADC code is below a threshold. The threshold takes one of two levels, picked by the value of the bit decided just before, so a marginal light level keeps the line in the state it already holds.

A frame is one start bit, eight data bits sent least significant bit first, one parity bit and one stop bit. A dark line is logic 0 and a light line is logic 1. A coarse light detector, which works without the sensor, wakes the receiver when the line turns from light to dark. The sensor is powered only while a frame is being received. A cycle-count timeout abandons a frame that stalls. Complete bytes come out with a one-clock valid strobe. Parity, framing and timeout faults raise sticky flags, which stay set until the next frame starts.

Top module: `lumen_uart_rx`

## Requirements
- R1: After reset, rx_vld_o, sens_en_o, adc_start_o, par_err_o, frm_err_o and tmo_o are 0 and rx_byte_o is 0.
- R2: While idle, a 1-to-0 change on coarse_lite_i starts a frame. In the following cycle sens_en_o is 1 and par_err_o, frm_err_o and tmo_o are all 0.
- R3: During a frame, every tick_i pulse gives one adc_start_o pulse in the same cycle, except the final tick of the stop bit. The first tick after the frame starts only primes the ADC. A complete frame therefore issues 88 conversions over 89 ticks.
- R4: The value judged on a tick is adc_data_i. A sample is dark when adc_data_i is below the active threshold. Only samples 3, 4 and 5 of a bit (numbered 0 to 7) count. A bit is 0 when at least 2 of those samples are dark, and 1 otherwise.
- R5: The active threshold is thr_zero_i at the start of a frame and after a bit decided as 0. It is thr_one_i after a bit decided as 1.
- R6: A start bit decided as 1 ends the frame with no byte and no flag, and sens_en_o and adc_start_o go low.
- R7: The data bits are assembled least significant bit first. When the stop bit is 1 and the parity is correct, rx_byte_o takes the byte and rx_vld_o is 1 for exactly one clock, in the cycle after the final tick.
- R8: With par_odd_i = 0 the expected parity bit is the XOR of the data bits. With par_odd_i = 1 it is the inverse of that XOR. A mismatch sets par_err_o, which stays set, and no rx_vld_o pulse follows.
- R9: A stop bit decided as 0 sets frm_err_o, which stays set, and no rx_vld_o pulse follows.
- R10: If a frame has not ended TMO_CYC clocks after it started, tmo_o goes to 1 and sens_en_o goes to 0.
- R11: sens_en_o is 1 from the start of a frame until the frame completes, is abandoned or times out, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Sample tick, one clock wide, 8 per bit |
| coarse_lite_i | input | 1 | Coarse light detector, 1 = light |
| adc_start_o | output | 1 | Starts an ADC conversion |
| adc_data_i | input | ADC_W | Result of the previous conversion |
| thr_zero_i | input | ADC_W | Dark threshold used after a 0 bit |
| thr_one_i | input | ADC_W | Dark threshold used after a 1 bit |
| par_odd_i | input | 1 | 1 = odd parity, 0 = even |
| sens_en_o | output | 1 | Light sensor power enable |
| rx_byte_o | output | DATA_W | Last good byte |
| rx_vld_o | output | 1 | One-clock strobe for rx_byte_o |
| par_err_o | output | 1 | Sticky parity error |
| frm_err_o | output | 1 | Sticky stop-bit error |
| tmo_o | output | 1 | Sticky receive timeout |

## Verification
Every one of the 256 byte values is sent in clean frames with even parity. This shows the LSB-first assembly, the parity computation and the conversion count across the whole data space. A group of values is sent again with odd parity to separate the two parity senses. Some frames carry dark samples only outside the central window, or too few inside it. These separate the central majority rule from a rule that counts any sample. Frames with a level between the two thresholds read as dark after a 0 and as light after a 1, which shows that the hysteresis goes in the right direction. A bad start bit, a wrong parity bit, a dark stop bit and a stalled tick stream each exercise one abort path and its flag.

// File: rtl/lr_pkg.sv
package lr_pkg;
  typedef enum logic [2:0] {
    RX_IDLE,
    RX_PRIME,
    RX_START,
    RX_DATA,
    RX_PARITY,
    RX_STOP
  } rx_state_e;
endpackage

// File: rtl/lr_bit_judge.sv
module lr_bit_judge #(
  parameter int ADC_W    = 8,
  parameter int SPB      = 8,
  parameter int DARK_MIN = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             smp_en_i,
  input  logic [ADC_W-1:0] adc_data_i,
  input  logic [ADC_W-1:0] thr_zero_i,
  input  logic [ADC_W-1:0] thr_one_i,
  output logic             bit_done_o,
  output logic             bit_val_o
);
  localparam int IDX_W  = $clog2(SPB);
  localparam int MID_LO = SPB / 2 - 1;
  localparam int MID_HI = SPB / 2 + 1;
  localparam int N_MID  = MID_HI - MID_LO + 1;
  localparam int CNT_W  = $clog2(N_MID + 1);

  logic [IDX_W-1:0] idx_q, idx_d;
  logic [CNT_W-1:0] dcnt_q, dcnt_d;
  logic             prev_q, prev_d;
  logic [ADC_W-1:0] thr;
  logic             dark, in_mid, last;

  assign thr        = prev_q ? thr_one_i : thr_zero_i;
  assign dark       = adc_data_i < thr;
  assign in_mid     = (idx_q >= IDX_W'(MID_LO)) && (idx_q <= IDX_W'(MID_HI));
  assign last       = idx_q == IDX_W'(SPB - 1);
  assign bit_done_o = smp_en_i && last;
  assign bit_val_o  = dcnt_q < CNT_W'(DARK_MIN);

  always_comb begin
    idx_d  = idx_q;
    dcnt_d = dcnt_q;
    prev_d = prev_q;
    if (clr_i) begin
      idx_d  = '0;
      dcnt_d = '0;
      prev_d = 1'b0;
    end else if (smp_en_i) begin
      if (last) begin
        idx_d  = '0;
        dcnt_d = '0;
        prev_d = bit_val_o;
      end else begin
        idx_d = idx_q + 1'b1;
        if (in_mid && dark) dcnt_d = dcnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      dcnt_q <= '0;
      prev_q <= 1'b0;
    end else begin
      idx_q  <= idx_d;
      dcnt_q <= dcnt_d;
      prev_q <= prev_d;
    end
  end

  AST_DCNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    dcnt_q <= CNT_W'(N_MID)); // R4
  AST_DCNT_FROZEN_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_en_i && !clr_i && !in_mid && !last) |=> $stable(dcnt_q)); // R4
endmodule

// File: rtl/lr_timeout.sv
module lr_timeout #(
  parameter int TMO_CYC = 1000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic run_i,
  output logic hit_o
);
  localparam int CW = $clog2(TMO_CYC + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign hit_o = run_i && (cnt_q == CW'(TMO_CYC - 1));

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)               cnt_d = '0;
    else if (run_i && !hit_o) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_TMO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CW'(TMO_CYC)); // R10
endmodule

// File: rtl/lr_frame_fsm.sv
module lr_frame_fsm
  import lr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_i,
  input  logic              tick_i,
  input  logic              bit_done_i,
  input  logic              bit_val_i,
  input  logic              tmo_hit_i,
  input  logic              par_odd_i,
  output logic              active_o,
  output logic              start_o,
  output logic              smp_en_o,
  output logic              adc_start_o,
  output logic [DATA_W-1:0] byte_o,
  output logic              vld_o,
  output logic              par_err_o,
  output logic              frm_err_o,
  output logic              tmo_o
);
  localparam int BCNT_W = $clog2(DATA_W);

  rx_state_e         state_q, state_d;
  logic [DATA_W-1:0] sh_q, sh_d, byte_q, byte_d;
  logic [BCNT_W-1:0] bcnt_q, bcnt_d;
  logic              vld_q, vld_d, perr_q, perr_d, ferr_q, ferr_d, tmo_q, tmo_d;

  assign start_o     = (state_q == RX_IDLE) && go_i;
  assign active_o    = state_q != RX_IDLE;
  assign smp_en_o    = tick_i && active_o && (state_q != RX_PRIME);
  assign adc_start_o = tick_i && active_o && !((state_q == RX_STOP) && bit_done_i);

  always_comb begin
    state_d = state_q;
    sh_d    = sh_q;
    byte_d  = byte_q;
    bcnt_d  = bcnt_q;
    vld_d   = 1'b0;
    perr_d  = perr_q;
    ferr_d  = ferr_q;
    tmo_d   = tmo_q;
    if (start_o) begin
      state_d = RX_PRIME;
      perr_d  = 1'b0;
      ferr_d  = 1'b0;
      tmo_d   = 1'b0;
    end else if (active_o && tmo_hit_i) begin
      state_d = RX_IDLE;
      tmo_d   = 1'b1;
    end else begin
      case (state_q)
        RX_PRIME: if (tick_i) state_d = RX_START;
        RX_START: if (bit_done_i) begin
          bcnt_d  = '0;
          state_d = bit_val_i ? RX_IDLE : RX_DATA;
        end
        RX_DATA: if (bit_done_i) begin
          sh_d = {bit_val_i, sh_q[DATA_W-1:1]};
          if (bcnt_q == BCNT_W'(DATA_W - 1)) state_d = RX_PARITY;
          else                                bcnt_d  = bcnt_q + 1'b1;
        end
        RX_PARITY: if (bit_done_i) begin
          perr_d  = bit_val_i != ((^sh_q) ^ par_odd_i);
          state_d = RX_STOP;
        end
        RX_STOP: if (bit_done_i) begin
          state_d = RX_IDLE;
          if (!bit_val_i) begin
            ferr_d = 1'b1;
          end else if (!perr_q) begin
            byte_d = sh_q;
            vld_d  = 1'b1;
          end
        end
        default: state_d = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      sh_q    <= '0;
      byte_q  <= '0;
      bcnt_q  <= '0;
      vld_q   <= 1'b0;
      perr_q  <= 1'b0;
      ferr_q  <= 1'b0;
      tmo_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      sh_q    <= sh_d;
      byte_q  <= byte_d;
      bcnt_q  <= bcnt_d;
      vld_q   <= vld_d;
      perr_q  <= perr_d;
      ferr_q  <= ferr_d;
      tmo_q   <= tmo_d;
    end
  end

  assign byte_o    = byte_q;
  assign vld_o     = vld_q;
  assign par_err_o = perr_q;
  assign frm_err_o = ferr_q;
  assign tmo_o     = tmo_q;

  AST_FLAGS_CLEAR_ON_GO: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> (!perr_q && !ferr_q && !tmo_q && active_o)); // R2
  AST_PRIME_NO_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RX_PRIME) |-> !smp_en_o); // R3
endmodule

// File: rtl/lumen_uart_rx.sv
module lumen_uart_rx #(
  parameter int ADC_W    = 8,
  parameter int DATA_W   = 8,
  parameter int SPB      = 8,
  parameter int DARK_MIN = 2,
  parameter int TMO_CYC  = 1000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              coarse_lite_i,
  output logic              adc_start_o,
  input  logic [ADC_W-1:0]  adc_data_i,
  input  logic [ADC_W-1:0]  thr_zero_i,
  input  logic [ADC_W-1:0]  thr_one_i,
  input  logic              par_odd_i,
  output logic              sens_en_o,
  output logic [DATA_W-1:0] rx_byte_o,
  output logic              rx_vld_o,
  output logic              par_err_o,
  output logic              frm_err_o,
  output logic              tmo_o
);
  logic rst_meta_q, rst_sync_n;
  logic lite_q, go;
  logic active, start, smp_en, bit_done, bit_val, tmo_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) lite_q <= 1'b0;
    else             lite_q <= coarse_lite_i;
  end

  assign go = lite_q && !coarse_lite_i;

  lr_frame_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .go_i       (go),
    .tick_i     (tick_i),
    .bit_done_i (bit_done),
    .bit_val_i  (bit_val),
    .tmo_hit_i  (tmo_hit),
    .par_odd_i  (par_odd_i),
    .active_o   (active),
    .start_o    (start),
    .smp_en_o   (smp_en),
    .adc_start_o(adc_start_o),
    .byte_o     (rx_byte_o),
    .vld_o      (rx_vld_o),
    .par_err_o  (par_err_o),
    .frm_err_o  (frm_err_o),
    .tmo_o      (tmo_o)
  );

  lr_bit_judge #(.ADC_W(ADC_W), .SPB(SPB), .DARK_MIN(DARK_MIN)) u_judge (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .clr_i      (start),
    .smp_en_i   (smp_en),
    .adc_data_i (adc_data_i),
    .thr_zero_i (thr_zero_i),
    .thr_one_i  (thr_one_i),
    .bit_done_o (bit_done),
    .bit_val_o  (bit_val)
  );

  lr_timeout #(.TMO_CYC(TMO_CYC)) u_tmo (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .clr_i (start),
    .run_i (active),
    .hit_o (tmo_hit)
  );

  assign sens_en_o = active;

  AST_ADC_GATED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    adc_start_o |-> (tick_i && sens_en_o)); // R3
  AST_VLD_ONE_CYC: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rx_vld_o |=> !rx_vld_o); // R7
  AST_VLD_NO_ERR: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rx_vld_o |-> (!par_err_o && !frm_err_o && !sens_en_o)); // R8
  AST_TMO_SENSOR_OFF: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(tmo_o) |-> !sens_en_o); // R10
endmodule

// File: tb/lumen_uart_rx_tb.sv
`timescale 1ns/1ps
module lumen_uart_rx_tb;
  localparam int TMO      = 400;
  localparam int FR_TICKS = 89;
  localparam logic [7:0] LITE = 8'd200;
  localparam logic [7:0] DARK = 8'd10;
  localparam logic [7:0] MIDL = 8'd110;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       lite = 1'b1;
  logic [7:0] adc_data = 8'd0;
  logic       par_odd = 1'b0;
  logic       adc_start, sens_en, vld, perr, ferr, tmo;
  logic [7:0] rx_byte;

  int n_chk = 0;
  int n_bad = 0;
  int adc_cnt;
  logic [7:0] smp [0:87];

  always #2.5 clk = ~clk;

  lumen_uart_rx #(.TMO_CYC(TMO)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .coarse_lite_i(lite),
    .adc_start_o(adc_start), .adc_data_i(adc_data),
    .thr_zero_i(8'd120), .thr_one_i(8'd100), .par_odd_i(par_odd),
    .sens_en_o(sens_en), .rx_byte_o(rx_byte), .rx_vld_o(vld),
    .par_err_o(perr), .frm_err_o(ferr), .tmo_o(tmo)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic build(input logic [7:0] d, input bit par, input bit stopb, input bit startb);
    for (int k = 0; k < 11; k++) begin
      bit b;
      if (k == 0)      b = startb;
      else if (k < 9)  b = d[k-1];
      else if (k == 9) b = par;
      else             b = stopb;
      for (int s = 0; s < 8; s++) smp[k*8+s] = b ? LITE : DARK;
    end
  endtask

  task automatic kick();
    @(negedge clk) lite = 1'b0;
    @(negedge clk) lite = 1'b1;
  endtask

  task automatic run_ticks(input int n);
    adc_cnt = 0;
    for (int t = 0; t < n; t++) begin
      @(negedge clk);
      adc_data = (t == 0) ? 8'd0 : smp[t-1];
      tick = 1'b1;
      #1;
      if (adc_start) adc_cnt++;
      @(negedge clk);
      tick = 1'b0;
    end
  endtask

  task automatic good_frame(input logic [7:0] exp, input string req);
    kick();
    run_ticks(FR_TICKS);
    chk(vld && rx_byte == exp && !perr && !ferr, req, {vld, rx_byte}, {1'b1, exp});
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog R7 actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(!vld && !sens_en && !adc_start && !perr && !ferr && !tmo && rx_byte == 8'h00,
        "R1 reset", {vld, sens_en, perr, ferr, tmo}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(!vld && !sens_en && !adc_start && !perr && !ferr && !tmo && rx_byte == 8'h00,
        "R1 after release", {vld, sens_en, perr, ferr, tmo}, 0);

    // R2 / R11: frame start powers the sensor
    build(8'h5A, ^8'h5A, 1'b1, 1'b0);
    kick();
    chk(sens_en && !perr && !ferr && !tmo, "R2 start", {sens_en, perr, ferr, tmo}, 8);
    run_ticks(FR_TICKS);
    chk(vld && rx_byte == 8'h5A, "R7 first byte", rx_byte, 8'h5A);
    chk(adc_cnt == 88, "R3 conversions per frame", adc_cnt, 88);
    chk(!sens_en, "R11 sensor off after frame", sens_en, 0);
    @(negedge clk);
    chk(!vld, "R7 strobe one clock", vld, 0);

    // R7 / R8 / R3: exhaustive even parity sweep
    par_odd = 1'b0;
    for (int v = 0; v < 256; v++) begin
      build(v[7:0], ^v[7:0], 1'b1, 1'b0);
      good_frame(v[7:0], "R7 R8 even sweep");
      chk(adc_cnt == 88, "R3 sweep conversions", adc_cnt, 88);
    end

    // R8: odd parity
    par_odd = 1'b1;
    for (int v = 0; v < 256; v += 17) begin
      build(v[7:0], ~^v[7:0], 1'b1, 1'b0);
      good_frame(v[7:0], "R8 odd parity");
    end
    // R8: wrong parity under odd mode (even-style bit)
    build(8'h3C, ^8'h3C, 1'b1, 1'b0);
    kick();
    run_ticks(FR_TICKS);
    chk(!vld && perr && !ferr, "R8 odd mismatch", {vld, perr, ferr}, 3'b010);
    par_odd = 1'b0;
    build(8'h3C, ~^8'h3C, 1'b1, 1'b0);
    kick();
    run_ticks(FR_TICKS);
    chk(!vld && perr, "R8 even mismatch", {vld, perr}, 2'b01);
    repeat (20) @(negedge clk);
    chk(perr, "R8 sticky", perr, 1);

    // R9: dark stop bit
    build(8'h81, ^8'h81, 1'b0, 1'b0);
    kick();
    chk(!perr, "R2 flag cleared", perr, 0);
    run_ticks(FR_TICKS);
    chk(!vld && ferr && !perr, "R9 framing", {vld, ferr, perr}, 3'b010);
    repeat (20) @(negedge clk);
    chk(ferr, "R9 sticky", ferr, 1);

    // R6: light start bit
    build(8'h00, 1'b0, 1'b1, 1'b1);
    kick();
    chk(!ferr, "R2 framing cleared", ferr, 0);
    run_ticks(9);
    chk(!sens_en && !vld && !perr && !ferr && !tmo, "R6 abandon",
        {sens_en, vld, perr, ferr, tmo}, 0);
    run_ticks(3);
    chk(adc_cnt == 0, "R6 no conversions when idle", adc_cnt, 0);

    // R4: only the central samples, majority of 2
    build(8'hA5, ^8'hAD, 1'b1, 1'b0);
    for (int s = 0; s < 8; s++) begin
      smp[1*8+s] = (s < 3 || s > 5) ? DARK : LITE;
      smp[2*8+s] = (s == 3 || s == 5) ? DARK : LITE;
      smp[3*8+s] = (s == 4) ? DARK : LITE;
      smp[4*8+s] = (s == 3) ? DARK : LITE;
    end
    good_frame(8'hAD, "R4 central majority");

    // R5: level between thresholds reads as dark after 0, light after 1
    build(8'hF6, ^8'hF6, 1'b1, 1'b0);
    for (int s = 0; s < 8; s++) begin
      smp[1*8+s] = MIDL;
      smp[3*8+s] = MIDL;
    end
    good_frame(8'hF6, "R5 hysteresis hold");
    build(8'h09, ^8'h0B, 1'b1, 1'b0);
    for (int s = 0; s < 8; s++) smp[2*8+s] = MIDL;
    good_frame(8'h0B, "R5 hysteresis after one");
    build(8'h00, ^8'h00, 1'b1, 1'b0);
    for (int s = 0; s < 8; s++) smp[1*8+s] = MIDL;
    good_frame(8'h00, "R5 zero level at frame start");

    // R10: stalled tick stream
    build(8'h77, ^8'h77, 1'b1, 1'b0);
    kick();
    run_ticks(20);
    chk(sens_en && !tmo, "R11 on mid frame", {sens_en, tmo}, 2'b10);
    repeat (TMO) @(negedge clk);
    chk(tmo && !sens_en && !vld, "R10 timeout", {tmo, sens_en, vld}, 3'b100);
    kick();
    chk(!tmo && sens_en, "R2 timeout cleared", {tmo, sens_en}, 2'b01);
    run_ticks(FR_TICKS);
    chk(vld && rx_byte == 8'h77 && !tmo, "R10 recovery", rx_byte, 8'h77);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule